// File: doc/BRIEF.md
# Extended-Precision Register Pushdown Stack

This block is a small register file for 80-bit extended-precision values (one sign bit, a 15-bit exponent and a 64-bit mantissa) arranged as a pushdown stack of eight entries. Software-visible slot numbers are relative: slot 0 is always the current top and slot 7 the deepest entry. A 3-bit top pointer maps a relative slot onto a physical register as (top + slot) modulo the depth. A push moves the pointer down by one and a pop moves it up by one, so no data is ever copied between registers.

The block accepts one operation per cycle on a valid-qualified opcode. It can clear the stack, push a loaded value, emit the top value with or without removing it, negate or take the absolute value of the top value by acting on its sign bit alone, and read any relative slot through a combinational read port. A per-register valid tag tracks occupancy. A push onto a full stack still happens: it overwrites the bottom entry and raises a one-cycle overflow pulse. Emitting from an empty stack returns zero and raises a one-cycle underflow pulse. Until the first clear operation after reset, every other request is ignored.

Top module: `pdstack_top`

## Requirements
- R1: After reset, `st_valid`, `underflow` and `overflow` are 0, and `rd_data` is zero for every relative slot.
- R2: Until the first accepted INIT after reset, every other opcode is ignored: it gives no `st_valid` and no pulse, and no slot contents change.
- R3: INIT (opcode 1) is accepted at any time, empties the stack and makes every slot read zero.
- R4: PUSH (opcode 2) writes `load_data` to relative slot 0, and each entry present before moves one slot deeper. The change is visible on `rd_data` in the cycle after the edge that takes the PUSH.
- R5: PEEK (opcode 3) sets `st_valid` for one cycle after the edge that takes it, with `st_data` equal to slot 0. The stack does not change.
- R6: POP (opcode 4) emits slot 0 the same way as PEEK, then removes it, so each deeper entry moves one slot up and the vacated bottom slot reads zero.
- R7: PEEK or POP on an empty stack gives `st_valid` with `st_data` zero and a one-cycle `underflow` pulse, and the stack stays unchanged.
- R8: PUSH onto a full stack overwrites the bottom entry and raises a one-cycle `overflow` pulse. The new value becomes slot 0, old slots 0..DEPTH-2 move one slot deeper, and the old bottom value is lost.
- R9: NEG (opcode 5) inverts the most significant bit (the sign) of slot 0, and ABS (opcode 6) clears it. All other bits stay the same, and neither opcode changes an empty stack.
- R10: `rd_data` shows the value in relative slot `rd_idx` combinationally, or zero if that slot is empty.
- R11: Opcodes 0 and 7 are no-operations: they change no slot and produce no `st_valid` and no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode on `op` is presented this cycle |
| op | input | 3 | Opcode: 0 nop, 1 init, 2 push, 3 peek, 4 pop, 5 neg, 6 abs, 7 nop |
| load_data | input | W (80) | Value written by a push |
| rd_idx | input | log2(DEPTH) (3) | Relative slot for the direct read port |
| rd_data | output | W (80) | Value in slot `rd_idx`, or zero if that slot is empty |
| st_valid | output | 1 | `st_data` holds a peek or pop result |
| st_data | output | W (80) | Top value emitted by peek or pop |
| underflow | output | 1 | One-cycle pulse: peek or pop on an empty stack |
| overflow | output | 1 | One-cycle pulse: push onto a full stack |

## Verification
The bench builds the stack with DEPTH 4, a 2-bit exponent and a 5-bit mantissa, which gives 8-bit entries and a 2-bit pointer. With this shape, the stack fills and wraps after a handful of pushes, and the top pointer passes through every physical position many times. A bench model tracks the stack by relative slot. After every operation, the bench reads back all four slots and compares the emitted value and both pulses against that model. Directed phases cover ignored operations before the first INIT, underflow, overflow with overwrite of the bottom entry, and the sign operations. A long pseudo-random operation stream then reaches every pointer value from every stack fill level.

// File: rtl/pdstack_pkg.sv
package pdstack_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_INIT = 3'd1,
      OP_PUSH = 3'd2,
      OP_PEEK = 3'd3,
      OP_POP  = 3'd4,
      OP_NEG  = 3'd5,
      OP_ABS  = 3'd6,
      OP_RSVD = 3'd7
   } stk_op_e;

endpackage

// File: rtl/pdstack_file.sv
// Storage: one register per physical slot, one write port, two read ports.
module pdstack_file #(
   parameter int DEPTH = 8,
   parameter int W     = 80,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_slot,
   input  logic [W-1:0]  wr_val,
   input  logic [PW-1:0] top_slot,
   input  logic [PW-1:0] rd_slot,
   output logic [W-1:0]  top_raw,
   output logic [W-1:0]  rd_raw
);

   logic [DEPTH-1:0][W-1:0] cells;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == PW'(g))) begin
            q <= wr_val;
         end
      end
      assign cells[g] = q;
   end

   assign top_raw = cells[top_slot];
   assign rd_raw  = cells[rd_slot];

endmodule

// File: rtl/pdstack_ctrl.sv
// Top pointer, occupancy tags, opcode decode and registered result/pulses.
module pdstack_ctrl
   import pdstack_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int W     = 80,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op,
   input  logic [W-1:0]     load_data,
   input  logic [W-1:0]     top_raw,
   output logic             ready,
   output logic [PW-1:0]    top_ptr,
   output logic [DEPTH-1:0] tag,
   output logic             wr_en,
   output logic [PW-1:0]    wr_slot,
   output logic [W-1:0]     wr_val,
   output logic             st_valid,
   output logic [W-1:0]     st_data,
   output logic             underflow,
   output logic             overflow
);

   stk_op_e       opc;
   logic          live;
   logic          has_top;
   logic [PW-1:0] push_slot;

   assign opc       = stk_op_e'(op);
   assign live      = op_valid && ready;
   assign has_top   = tag[top_ptr];
   assign push_slot = top_ptr - PW'(1);

   always_comb begin
      wr_en   = 1'b0;
      wr_slot = top_ptr;
      wr_val  = top_raw;
      if (live) begin
         unique case (opc)
            OP_PUSH: begin
               wr_en   = 1'b1;
               wr_slot = push_slot;
               wr_val  = load_data;
            end
            OP_NEG: begin
               wr_en  = has_top;
               wr_val = {~top_raw[W-1], top_raw[W-2:0]};
            end
            OP_ABS: begin
               wr_en  = has_top;
               wr_val = {1'b0, top_raw[W-2:0]};
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready     <= 1'b0;
         top_ptr   <= '0;
         tag       <= '0;
         st_valid  <= 1'b0;
         st_data   <= '0;
         underflow <= 1'b0;
         overflow  <= 1'b0;
      end else begin
         st_valid  <= 1'b0;
         underflow <= 1'b0;
         overflow  <= 1'b0;
         if (op_valid && opc == OP_INIT) begin
            ready   <= 1'b1;
            top_ptr <= '0;
            tag     <= '0;
         end else if (live) begin
            unique case (opc)
               OP_PUSH: begin
                  top_ptr        <= push_slot;
                  tag[push_slot] <= 1'b1;
                  overflow       <= tag[push_slot];
               end
               OP_PEEK, OP_POP: begin
                  st_valid  <= 1'b1;
                  st_data   <= has_top ? top_raw : '0;
                  underflow <= !has_top;
                  if (opc == OP_POP && has_top) begin
                     tag[top_ptr] <= 1'b0;
                     top_ptr      <= top_ptr + PW'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pdstack_top.sv
module pdstack_top #(
   parameter int  DEPTH = 8,
   parameter int  EXP_W = 15,
   parameter int  MAN_W = 64,
   localparam int W     = 1 + EXP_W + MAN_W,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [2:0]    op,
   input  logic [W-1:0]  load_data,
   input  logic [PW-1:0] rd_idx,
   output logic [W-1:0]  rd_data,
   output logic          st_valid,
   output logic [W-1:0]  st_data,
   output logic          underflow,
   output logic          overflow
);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("pdstack_top: DEPTH must be a power of two of at least 2");
   end
   if (EXP_W < 1 || MAN_W < 1) begin : g_bad_fmt
      $error("pdstack_top: exponent and mantissa need at least one bit");
   end

   logic             ready;
   logic [PW-1:0]    top_ptr;
   logic [DEPTH-1:0] tag;
   logic             wr_en;
   logic [PW-1:0]    wr_slot;
   logic [W-1:0]     wr_val;
   logic [W-1:0]     top_raw;
   logic [W-1:0]     rd_raw;
   logic [PW-1:0]    rd_phys;
   logic [W-1:0]     top_live;

   assign rd_phys  = top_ptr + rd_idx;
   assign rd_data  = tag[rd_phys] ? rd_raw : '0;
   assign top_live = tag[top_ptr] ? top_raw : '0;

   pdstack_ctrl #(.DEPTH(DEPTH), .W(W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op        (op),
      .load_data (load_data),
      .top_raw   (top_raw),
      .ready     (ready),
      .top_ptr   (top_ptr),
      .tag       (tag),
      .wr_en     (wr_en),
      .wr_slot   (wr_slot),
      .wr_val    (wr_val),
      .st_valid  (st_valid),
      .st_data   (st_data),
      .underflow (underflow),
      .overflow  (overflow)
   );

   pdstack_file #(.DEPTH(DEPTH), .W(W)) u_file (
      .clk      (clk),
      .wr_en    (wr_en),
      .wr_slot  (wr_slot),
      .wr_val   (wr_val),
      .top_slot (top_ptr),
      .rd_slot  (rd_phys),
      .top_raw  (top_raw),
      .rd_raw   (rd_raw)
   );

endmodule

// File: rtl/pdstack_chk.sv
module pdstack_chk #(
   parameter int DEPTH = 8,
   parameter int W     = 80,
   localparam int PW   = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op,
   input logic [W-1:0]     load_data,
   input logic             ready,
   input logic [PW-1:0]    top_ptr,
   input logic [DEPTH-1:0] tag,
   input logic [W-1:0]     top_live,
   input logic             st_valid,
   input logic [W-1:0]     st_data,
   input logic             underflow,
   input logic             overflow
);

   logic acc;
   assign acc = op_valid && ready;

   a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(underflow && overflow));

   a_r2_ignored_before_init: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && op_valid && op != 3'd1) |=>
         (!st_valid && !overflow && !underflow && !ready && $stable(top_ptr) && $stable(tag)));

   a_r4_push_lands_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd2) |=> (top_live == $past(load_data)));

   a_r5_peek_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd3) |=> (st_valid && $stable(top_ptr) && $stable(tag) && $stable(top_live)));

   a_r6_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd4 && tag[top_ptr]) |=>
         (st_valid && st_data == $past(top_live) && top_ptr == PW'($past(top_ptr) + PW'(1))));

   a_r7_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (st_valid && st_data == '0 && $stable(tag)));

   a_r8_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> ($past(&tag) && (&tag)));

   a_r9_neg_flips_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd5 && tag[top_ptr]) |=>
         (top_live == {~$past(top_live[W-1]), $past(top_live[W-2:0])}));

   a_r9_abs_clears_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd6 && tag[top_ptr]) |=>
         (top_live == {1'b0, $past(top_live[W-2:0])}));

endmodule

bind pdstack_top pdstack_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op        (op),
   .load_data (load_data),
   .ready     (ready),
   .top_ptr   (top_ptr),
   .tag       (tag),
   .top_live  (top_live),
   .st_valid  (st_valid),
   .st_data   (st_data),
   .underflow (underflow),
   .overflow  (overflow)
);

// File: tb/pdstack_top_tb.sv
`timescale 1ns/100ps
module pdstack_top_tb;

   localparam int DEPTH = 4;
   localparam int EXP_W = 2;
   localparam int MAN_W = 5;
   localparam int W     = 1 + EXP_W + MAN_W;
   localparam int PW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [2:0]    op = 3'd0;
   logic [W-1:0]  load_data = '0;
   logic [PW-1:0] rd_idx = '0;
   logic [W-1:0]  rd_data;
   logic          st_valid;
   logic [W-1:0]  st_data;
   logic          underflow;
   logic          overflow;

   always #5 clk = ~clk;

   pdstack_top #(.DEPTH(DEPTH), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op        (op),
      .load_data (load_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .st_valid  (st_valid),
      .st_data   (st_data),
      .underflow (underflow),
      .overflow  (overflow)
   );

   int         nvec = 0;
   int         nbad = 0;
   logic [W-1:0] m [DEPTH];
   int         cnt = 0;
   bit         rdy = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < DEPTH; i++) begin
         rd_idx = PW'(i);
         #0.5;
         chk({req, " R10 slot read"}, rd_data, (i < cnt) ? m[i] : '0);
      end
   endtask

   function automatic string req_of(input logic [2:0] o, input bit ready_now);
      if (!ready_now && o != 3'd1) return "R2";
      case (o)
         3'd1: return "R3";
         3'd2: return (cnt == DEPTH) ? "R8" : "R4";
         3'd3: return (cnt == 0) ? "R7" : "R5";
         3'd4: return (cnt == 0) ? "R7" : "R6";
         3'd5, 3'd6: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [W-1:0] d);
      string       r;
      bit          e_sv, e_un, e_ov;
      logic [W-1:0] e_sd;
      r    = req_of(o, rdy);
      e_sv = rdy && (o == 3'd3 || o == 3'd4);
      e_sd = (e_sv && cnt > 0) ? m[0] : '0;
      e_un = e_sv && cnt == 0;
      e_ov = rdy && o == 3'd2 && cnt == DEPTH;
      @(negedge clk);
      op_valid  = 1'b1;
      op        = o;
      load_data = d;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      // reference model update
      if (o == 3'd1) begin
         rdy = 1;
         cnt = 0;
      end else if (rdy) begin
         case (o)
            3'd2: begin
               for (int i = DEPTH - 1; i > 0; i--) m[i] = m[i-1];
               m[0] = d;
               if (cnt < DEPTH) cnt++;
            end
            3'd4: if (cnt > 0) begin
               for (int i = 0; i < DEPTH - 1; i++) m[i] = m[i+1];
               cnt--;
            end
            3'd5: if (cnt > 0) m[0][W-1] = ~m[0][W-1];
            3'd6: if (cnt > 0) m[0][W-1] = 1'b0;
            default: ;
         endcase
      end
      chk({r, " st_valid"}, W'(st_valid), W'(e_sv));
      chk({r, " underflow"}, W'(underflow), W'(e_un));
      chk({r, " overflow"}, W'(overflow), W'(e_ov));
      if (e_sv) chk({r, " st_data"}, st_data, e_sd);
      sweep(r);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < DEPTH; i++) m[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 st_valid", W'(st_valid), '0);
      chk("R1 underflow", W'(underflow), '0);
      chk("R1 overflow", W'(overflow), '0);
      sweep("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      sweep("R1");

      // R2: everything but INIT is ignored before the first INIT
      apply(3'd2, 8'h3C);
      apply(3'd3, 8'h00);
      apply(3'd4, 8'h00);
      apply(3'd5, 8'h00);
      apply(3'd6, 8'h00);
      apply(3'd7, 8'h00);
      apply(3'd2, 8'hA5);

      // R3: first INIT
      apply(3'd1, 8'h00);

      // R7 and R9 on an empty stack
      apply(3'd3, 8'h00);
      apply(3'd4, 8'h00);
      apply(3'd5, 8'h00);
      apply(3'd6, 8'h00);

      // R4 then R8: fill, then wrap twice
      for (int i = 0; i < DEPTH + 2; i++) apply(3'd2, W'(8'h11 * (i + 1)));
      apply(3'd3, 8'h00);         // R5
      apply(3'd5, 8'h00);         // R9 neg
      apply(3'd5, 8'h00);         // R9 neg back
      apply(3'd2, 8'hF0);         // R8
      apply(3'd6, 8'h00);         // R9 abs
      apply(3'd0, 8'hFF);         // R11
      apply(3'd7, 8'hFF);         // R11
      for (int i = 0; i < DEPTH + 2; i++) apply(3'd4, 8'h00);  // R6, then R7
      apply(3'd2, 8'h81);
      apply(3'd2, 8'h82);
      apply(3'd1, 8'h00);         // R3 on a non-empty stack
      apply(3'd3, 8'h00);

      // pseudo-random stream
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] o;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         o = lfsr[2:0];
         if (o == 3'd1 && lfsr[6:3] != 4'd0) o = 3'd2;
         apply(o, lfsr[15:8]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule